// File: doc/BRIEF.md
# Debounced Serial Clock Edge Detector

This block watches a slow, open-collector serial clock line, such as the clock wire of a keyboard or mouse port, and reports its transitions. The block samples the line with a fast system clock, and the line can carry glitches and slow, ringing edges. The raw sample first passes through a chain of synchroniser flops. A one-hot state machine then follows the synchronised level. A change of level counts as an edge only when the line holds its new level for a fixed number of system clock cycles. A shorter excursion is dropped without any output.

For each confirmed falling edge the block gives a single-cycle `fall_pulse`, and for each confirmed rising edge a single-cycle `rise_pulse`. The debounced level `line_level` changes in the same cycle as the pulse. A receiver or transmitter shift engine downstream can use the pulses as bit strobes. The idle line is pulled high, so after reset the block is in its stable-high state.

The machine has six states. STABLE_HIGH goes to FALL_SEEN when the synchronised line reads low. FALL_SEEN goes to FALL_HOLD if the line is still low, or back to STABLE_HIGH if it is high. FALL_HOLD counts low cycles. It aborts to STABLE_HIGH if the line reads high, and it goes to STABLE_LOW with a fall pulse when the count completes. STABLE_LOW goes to RISE_SEEN when the line reads high. RISE_SEEN goes to RISE_HOLD if the line is still high, or back to STABLE_LOW if it is low. RISE_HOLD counts high cycles. It aborts to STABLE_LOW if the line reads low, and it goes to STABLE_HIGH with a rise pulse when the count completes.

Top module: `clk_edge_qualifier`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) forces `line_level` to 1 and both pulses to 0, clears the hold counter and puts the machine in STABLE_HIGH. The synchroniser flops reset to 1.
- R2: The raw line passes through `SYNC_STAGES` (default 2) flops before the state machine samples it. A change on `line_raw` therefore cannot affect any output before the first `SYNC_STAGES + 2 + HOLD_CYCLES` edges.
- R3: `line_raw` may fall and then stay low. Count the first clock edge after the change as edge 1. `fall_pulse` is then high exactly after edge `SYNC_STAGES + 2 + HOLD_CYCLES`, which is edge 374 with the defaults (`HOLD_CYCLES` = 370, 10-bit counter).
- R4: `line_level` is 1 in STABLE_HIGH, FALL_SEEN and FALL_HOLD, and 0 in the other three states. It drops in the cycle `fall_pulse` is high and rises in the cycle `rise_pulse` is high.
- R5: `fall_pulse` is high for exactly one cycle per confirmed falling edge.
- R6: `rise_pulse` follows the same rule as R3 for a rise that stays high. It is high for exactly one cycle, at edge 374 with the defaults.
- R7: The line may return to its prior level while the machine is in a SEEN or HOLD state. The machine then goes back to the prior stable state, with no pulse and no change of `line_level`, and the hold count restarts. With the defaults, a raw excursion lasting 371 cycles gives no pulse and one lasting 372 cycles gives one pulse.
- R8: `fall_pulse` and `rise_pulse` are never high in the same cycle. The state register is always one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_raw | input | 1 | Raw sample of the serial clock line |
| fall_pulse | output | 1 | One-cycle strobe on a confirmed falling edge |
| rise_pulse | output | 1 | One-cycle strobe on a confirmed rising edge |
| line_level | output | 1 | Debounced line level |

## Verification
A confirmed edge shows up on the outputs after the synchroniser delay, one cycle in the SEEN state and the full hold count. That is 374 edges with the defaults, counted from the first clock edge after the raw change. The bench drives `line_raw` on falling clock edges and keeps its own shift chain and run-length counter of cycles spent away from the stable level. On every falling edge it compares both pulses and the level with that prediction, so a pulse that comes one cycle early or late is reported. Directed segments of 371 and 372 cycles probe the confirmation boundary. Random segments of mixed length exercise aborts and confirmations in both directions.

// File: rtl/clk_edge_pkg.sv
package clk_edge_pkg;

    typedef enum logic [5:0] {
        ST_STABLE_HIGH = 6'b000001,
        ST_FALL_SEEN   = 6'b000010,
        ST_FALL_HOLD   = 6'b000100,
        ST_STABLE_LOW  = 6'b001000,
        ST_RISE_SEEN   = 6'b010000,
        ST_RISE_HOLD   = 6'b100000
    } edge_state_t;

    function automatic logic level_of(input edge_state_t s);
        return (s == ST_STABLE_HIGH) || (s == ST_FALL_SEEN) || (s == ST_FALL_HOLD);
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int HOLD_CYCLES = 370,
    localparam int CNT_W = $clog2(HOLD_CYCLES) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);

    // R3: the count never runs past the last hold cycle
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
    // R7: a clear restarts the hold count
    a_r7_clear_restarts: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/edge_fsm.sv
module edge_fsm
    import clk_edge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_s,
    input  logic t_done,
    output logic t_clr,
    output logic t_inc,
    output logic fall_pulse,
    output logic rise_pulse,
    output logic line_level
);
    edge_state_t st, nxt;
    logic fall_set, rise_set;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_STABLE_HIGH;
        else     st <= nxt;
    end

    always_comb begin
        nxt      = st;
        t_clr    = 1'b1;
        t_inc    = 1'b0;
        fall_set = 1'b0;
        rise_set = 1'b0;
        unique case (st)
            ST_STABLE_HIGH: if (!line_s) nxt = ST_FALL_SEEN;
            ST_FALL_SEEN:   nxt = line_s ? ST_STABLE_HIGH : ST_FALL_HOLD;
            ST_FALL_HOLD: begin
                if (line_s) begin
                    nxt = ST_STABLE_HIGH;
                end else if (t_done) begin
                    nxt      = ST_STABLE_LOW;
                    fall_set = 1'b1;
                end else begin
                    t_clr = 1'b0;
                    t_inc = 1'b1;
                end
            end
            ST_STABLE_LOW:  if (line_s) nxt = ST_RISE_SEEN;
            ST_RISE_SEEN:   nxt = line_s ? ST_RISE_HOLD : ST_STABLE_LOW;
            ST_RISE_HOLD: begin
                if (!line_s) begin
                    nxt = ST_STABLE_LOW;
                end else if (t_done) begin
                    nxt      = ST_STABLE_HIGH;
                    rise_set = 1'b1;
                end else begin
                    t_clr = 1'b0;
                    t_inc = 1'b1;
                end
            end
            default: nxt = ST_STABLE_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_pulse <= 1'b0;
            rise_pulse <= 1'b0;
            line_level <= 1'b1;
        end else begin
            fall_pulse <= fall_set;
            rise_pulse <= rise_set;
            line_level <= level_of(nxt);
        end
    end

    // R8: state stays one-hot, pulses never coincide
    a_r8_state_onehot: assert property (@(posedge clk) disable iff (rst) $onehot(st));
    a_r8_pulse_excl:   assert property (@(posedge clk) disable iff (rst)
        !(fall_pulse && rise_pulse));
    // R5 / R6: single-cycle strobes
    a_r5_fall_single:  assert property (@(posedge clk) disable iff (rst)
        fall_pulse |=> !fall_pulse);
    a_r6_rise_single:  assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);
    // R4: level agrees with the pulse that moved it
    a_r4_level_fall:   assert property (@(posedge clk) disable iff (rst)
        fall_pulse |-> (!line_level && st == ST_STABLE_LOW));
    a_r4_level_rise:   assert property (@(posedge clk) disable iff (rst)
        rise_pulse |-> (line_level && st == ST_STABLE_HIGH));
    // R7: abort returns to the prior stable state with no strobe
    a_r7_fall_abort:   assert property (@(posedge clk) disable iff (rst)
        (st == ST_FALL_HOLD && line_s) |=> (st == ST_STABLE_HIGH && !fall_pulse && line_level));
    a_r7_rise_abort:   assert property (@(posedge clk) disable iff (rst)
        (st == ST_RISE_HOLD && !line_s) |=> (st == ST_STABLE_LOW && !rise_pulse && !line_level));
endmodule

// File: rtl/clk_edge_qualifier.sv
module clk_edge_qualifier #(
    parameter int HOLD_CYCLES = 370,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_raw,
    output logic fall_pulse,
    output logic rise_pulse,
    output logic line_level
);
    logic line_s;
    logic t_clr, t_inc, t_done;

    line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (line_raw),
        .dout (line_s)
    );

    hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (t_clr),
        .inc  (t_inc),
        .done (t_done)
    );

    edge_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .line_s     (line_s),
        .t_done     (t_done),
        .t_clr      (t_clr),
        .t_inc      (t_inc),
        .fall_pulse (fall_pulse),
        .rise_pulse (rise_pulse),
        .line_level (line_level)
    );

    // R1: reset leaves the block high and quiet
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (line_level && !fall_pulse && !rise_pulse));
endmodule

// File: tb/clk_edge_qualifier_test.sv
module clk_edge_qualifier_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 370;
    localparam int SYNC = 2;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_raw = 1'b1;
    logic fall_pulse, rise_pulse, line_level;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_fall = 0;
    int n_rise = 0;
    int last_fall_cyc = 0;
    int last_rise_cyc = 0;
    bit done_flag = 0;

    // bench reference model
    logic m_s1 = 1, m_s2 = 1, m_lvl = 1, m_fall = 0, m_rise = 0;
    int   m_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_edge_qualifier #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst(rst), .line_raw(line_raw),
        .fall_pulse(fall_pulse), .rise_pulse(rise_pulse), .line_level(line_level)
    );

    function automatic int away_edges_needed();
        return HOLD + 2;
    endfunction

    function automatic int edge_latency();
        return SYNC + 2 + HOLD;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_lvl = 1; m_run = 0; m_fall = 0; m_rise = 0;
        end else begin
            m_fall = 0; m_rise = 0;
            if (m_s2 != m_lvl) begin
                m_run++;
                if (m_run == away_edges_needed()) begin
                    m_lvl = m_s2;
                    m_run = 0;
                    if (m_s2) m_rise = 1; else m_fall = 1;
                end
            end else begin
                m_run = 0;
            end
            m_s2 = m_s1;
            m_s1 = line_raw;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // one cycle: compare at negedge, then drive
    task automatic step(input logic val);
        @(negedge clk);
        cyc++;
        if (!rst) begin
            check(fall_pulse == m_fall, "R3 R5 R7 fall_pulse", fall_pulse, m_fall);
            check(rise_pulse == m_rise, "R6 R7 rise_pulse", rise_pulse, m_rise);
            check(line_level == m_lvl, "R4 line_level", line_level, m_lvl);
            check(!(fall_pulse && rise_pulse), "R8 pulses coincide", 1, 0);
            if (fall_pulse) begin n_fall++; last_fall_cyc = cyc; end
            if (rise_pulse) begin n_rise++; last_rise_cyc = cyc; end
        end
        line_raw = val;
    endtask

    task automatic hold(input logic val, input int n);
        for (int i = 0; i < n; i++) step(val);
    endtask

    initial begin
        int start, f0, r0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(line_level == 1'b1, "R1 level in reset", line_level, 1);
        check(fall_pulse == 1'b0 && rise_pulse == 1'b0, "R1 pulses in reset", fall_pulse | rise_pulse, 0);
        rst = 1'b0;
        hold(1'b1, 10);
        check(line_level == 1'b1, "R1 level after reset", line_level, 1);

        // R7: 371-cycle low excursion is dropped
        f0 = n_fall;
        hold(1'b0, away_edges_needed() - 1);
        hold(1'b1, 400);
        check(n_fall == f0, "R7 short low gives no pulse", n_fall - f0, 0);
        check(line_level == 1'b1, "R7 level unchanged", line_level, 1);

        // R3 / R2: 372-cycle low confirms at exact latency
        f0 = n_fall;
        step(1'b0);
        start = cyc;
        hold(1'b0, edge_latency() + 20);
        check(n_fall == f0 + 1, "R3 R5 one fall pulse", n_fall - f0, 1);
        check(last_fall_cyc - start == edge_latency(), "R2 R3 fall latency",
              last_fall_cyc - start, edge_latency());
        check(line_level == 1'b0, "R4 level low", line_level, 0);

        // R7: short high while low
        r0 = n_rise;
        hold(1'b1, away_edges_needed() - 1);
        hold(1'b0, 400);
        check(n_rise == r0, "R7 short high gives no pulse", n_rise - r0, 0);

        // R6 rise latency
        step(1'b1);
        start = cyc;
        hold(1'b1, edge_latency() + 20);
        check(n_rise == r0 + 1, "R6 one rise pulse", n_rise - r0, 1);
        check(last_rise_cyc - start == edge_latency(), "R6 rise latency",
              last_rise_cyc - start, edge_latency());

        // R7: chatter during hold restarts the count
        f0 = n_fall;
        for (int k = 0; k < 5; k++) begin
            hold(1'b0, 200);
            hold(1'b1, 1);
        end
        hold(1'b1, 50);
        check(n_fall == f0, "R7 chatter gives no pulse", n_fall - f0, 0);

        // random segments
        for (int s = 0; s < 90; s++) begin
            int len;
            case ($urandom_range(0, 3))
                0: len = $urandom_range(1, 8);
                1: len = $urandom_range(360, 380);
                2: len = $urandom_range(100, 371);
                default: len = $urandom_range(372, 700);
            endcase
            hold(s[0], len);
        end
        hold(1'b1, 800);
        check(line_level == 1'b1, "R4 final level high", line_level, 1);

        // R1: reset mid-activity
        hold(1'b0, 100);
        rst = 1'b1;
        hold(1'b1, 3);
        check(line_level == 1'b1 && !fall_pulse && !rise_pulse, "R1 reset again",
              line_level, 1);
        rst = 1'b0;
        hold(1'b1, 20);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end
endmodule